// File: doc/BRIEF.md
# AC-link capture frame deserializer

This block is the receiving half of an AC-link controller. It watches the serial input line, the bit clock and the frame marker, all sampled in the controller's own system clock domain. It finds each frame from the rising edge of the frame marker and cuts the 256-bit frame into a 16-bit tag slot followed by twelve 20-bit slots. It then forwards only the slots that the tag slot marks as valid.

Each valid audio slot produces a one-cycle strobe on a lane of its own. The sample comes from the top 18 bits of the slot and is rounded, never truncated, to the configured output width. A register read-back produces one strobe that carries both the echoed register index and the data. The per-slot sample-request flags and the codec-ready status are held until the next frame updates them. When the codec reports that it is not ready, the whole frame is dropped.

Top module: `aclink_capture_rx`

## Requirements
- R1: After reset `codec_ready`, `sr_need`, `smp_stb` and `rd_valid` are all 0.
- R2: `codec_ready` takes the value of the first bit (tag bit 15) of the most recent complete tag slot, and it changes only when a tag slot completes.
- R3: In a frame whose tag bit 15 is 0, no sample strobe and no read strobe is produced and `sr_need` becomes all zeros, whatever the other tag bits hold.
- R4: Audio slot n (n in 3, 4, 6, 7, 8, 11) raises its strobe only when tag bit 15 and tag bit 15-n are both 1. The strobe lanes are `smp_stb[0..5]` = slots 3, 4, 6, 7, 8, 11.
- R5: Slots 5, 9, 10 and 12 never produce a strobe, even when their tag bits are 1.
- R6: The sample is slot bits 19..2, taken as an 18-bit two's-complement value (slot bit 19 is the first bit received). It is rounded to OUT_W bits as floor((v + 2^(17-OUT_W)) / 2^(18-OUT_W)). Slot bits 1..0 have no effect.
- R7: When rounding would exceed the largest positive OUT_W-bit value, the result is clamped to 2^(OUT_W-1)-1.
- R8: `rd_valid` pulses for one cycle after slot 2 only when tag bits 15, 14 and 13 are all 1. `rd_data` is then slot 2 bits 19..4 and `rd_index` is slot 1 bits 18..12 of the same frame. `rd_valid` never coincides with a sample strobe.
- R9: When slot 1 is accepted (tag bits 15 and 14 both 1), `sr_need[i]` becomes the inverse of slot 1 bit {11,10,8,7,6,5,4,3}[i], giving the lanes for slots 3, 4, 6, 7, 8, 9, 10, 11. When slot 1 is not accepted, `sr_need` becomes 0. `sr_need` changes only when slot 1 completes.
- R10: A rising frame marker makes that bit the first bit of a new frame. A slot that was not complete at that moment is dropped, even if this bit would have been its last.
- R11: Sample strobes are one-hot, and each strobe lasts one cycle.
- R12: Bits after the 256th bit of a frame, or before the first frame marker, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_clk | input | 1 | Link bit clock; data is taken on its falling edge |
| sync_in | input | 1 | Frame marker |
| sdata_in | input | 1 | Serial capture data |
| codec_ready | output | 1 | Codec-ready status from the last tag slot |
| smp_stb | output | 6 | One-cycle strobe per audio slot (3, 4, 6, 7, 8, 11) |
| smp_data | output | OUT_W | Rounded sample, valid with a strobe |
| rd_valid | output | 1 | Register read-back strobe |
| rd_index | output | 7 | Echoed register index |
| rd_data | output | 16 | Register read-back data |
| sr_need | output | 8 | New-sample-needed flags for slots 3, 4, 6..11 |

## Verification
The two functions that can fall on the same bit are the end of a slot and the restart of a frame. A frame marker that rises exactly on the last bit of slot 3 must start a new frame and must drop slot 3. The bench provokes this by cutting a frame at bit 75 and starting the next frame at once. Its reference model expects strobes only for slots whose 20 bits were all sent before the cut, so any strobe for the cut slot 3 is reported as unexpected.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
  localparam int CAP_W     = 18;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int LAST_SLOT = 12;
  localparam int N_AUDIO   = 6;
  localparam int N_REQ     = 8;

  // Round an 18-bit two's-complement capture to 'width' bits (right aligned,
  // sign extended), adding half an output LSB and clamping positive overflow.
  function automatic logic [CAP_W-1:0] round_narrow(input logic [CAP_W-1:0] raw,
                                                    input int unsigned width);
    logic [CAP_W:0]   ext;
    logic [CAP_W:0]   half;
    logic [CAP_W:0]   sum;
    logic [CAP_W-1:0] maxpos;
    if (width >= CAP_W) return raw;
    ext    = {raw[CAP_W-1], raw};
    half   = (CAP_W+1)'(1) << (CAP_W - 1 - width);
    sum    = ext + half;
    maxpos = (CAP_W'(1) << (width - 1)) - CAP_W'(1);
    if (!sum[CAP_W] && sum[CAP_W-1]) return maxpos;
    return CAP_W'($signed(sum) >>> (CAP_W - width));
  endfunction

  // Last bit position inside a slot, counted from 0.
  function automatic logic [4:0] slot_last_pos(input logic [3:0] idx);
    return (idx == 4'd0) ? 5'(TAG_BITS - 1) : 5'(SLOT_BITS - 1);
  endfunction
endpackage

// File: rtl/aclink_rx_sampler.sv
module aclink_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic sync_in,
  input  logic sdata_in,
  output logic bit_stb,
  output logic bit_dat,
  output logic bit_sync
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bc_q;
  logic [TOP:0] sy_q;
  logic [TOP:0] sd_q;
  logic         bc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q    <= '0;
      sy_q    <= '0;
      sd_q    <= '0;
      bc_last <= 1'b0;
    end else begin
      bc_q    <= {bc_q[TOP-1:0], bit_clk};
      sy_q    <= {sy_q[TOP-1:0], sync_in};
      sd_q    <= {sd_q[TOP-1:0], sdata_in};
      bc_last <= bc_q[TOP];
    end
  end

  // falling edge of the bit clock: take data and frame marker together
  assign bit_stb  = bc_last & ~bc_q[TOP];
  assign bit_dat  = sd_q[TOP];
  assign bit_sync = sy_q[TOP];
endmodule

// File: rtl/aclink_rx_framer.sv
module aclink_rx_framer
  import aclink_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 bit_dat,
  input  logic                 bit_sync,
  output logic                 slot_end,
  output logic [3:0]           slot_num,
  output logic [SLOT_BITS-1:0] slot_word
);
  logic                 sync_last;
  logic                 framed;
  logic [3:0]           slot_idx;
  logic [4:0]           pos;
  logic [SLOT_BITS-1:0] shreg;
  logic [SLOT_BITS-1:0] word_next;
  logic                 sync_rise;
  logic                 at_last;

  assign sync_rise = bit_sync & ~sync_last;
  assign word_next = {shreg[SLOT_BITS-2:0], bit_dat};
  assign at_last   = (pos == slot_last_pos(slot_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_last <= 1'b0;
      framed    <= 1'b0;
      slot_idx  <= '0;
      pos       <= '0;
      shreg     <= '0;
      slot_end  <= 1'b0;
      slot_num  <= '0;
      slot_word <= '0;
    end else begin
      slot_end <= 1'b0;
      if (bit_stb) begin
        sync_last <= bit_sync;
        if (sync_rise) begin
          // restart wins over any slot that would end on this bit
          framed   <= 1'b1;
          slot_idx <= '0;
          pos      <= 5'd1;
          shreg    <= {{(SLOT_BITS-1){1'b0}}, bit_dat};
        end else if (framed) begin
          shreg <= word_next;
          if (at_last) begin
            slot_end  <= 1'b1;
            slot_num  <= slot_idx;
            slot_word <= word_next;
            pos       <= '0;
            if (slot_idx == 4'(LAST_SLOT)) framed <= 1'b0;
            else slot_idx <= slot_idx + 4'd1;
          end else begin
            pos <= pos + 5'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aclink_rx_decode.sv
module aclink_rx_decode
  import aclink_rx_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_end,
  input  logic [3:0]           slot_num,
  input  logic [SLOT_BITS-1:0] slot_word,
  output logic                 codec_ready,
  output logic [N_AUDIO-1:0]   smp_stb,
  output logic [OUT_W-1:0]     smp_data,
  output logic                 rd_valid,
  output logic [6:0]           rd_index,
  output logic [15:0]          rd_data,
  output logic [N_REQ-1:0]     sr_need
);
  localparam int AUDIO_SLOT [N_AUDIO] = '{3, 4, 6, 7, 8, 11};

  logic [15:3]          tag_q;
  logic [6:0]           idx_q;
  logic                 tag_hit;
  logic                 slot_ok;
  logic [N_AUDIO-1:0]   hit;
  logic [CAP_W-1:0]     rounded;
  logic                 unused_low;

  always_comb begin
    tag_hit = 1'b0;
    for (int k = 1; k <= LAST_SLOT; k++)
      if (slot_num == 4'(k)) tag_hit = tag_q[15-k];
  end

  assign slot_ok    = slot_end & tag_q[15] & tag_hit;
  assign rounded    = round_narrow(slot_word[SLOT_BITS-1:2], OUT_W);
  assign unused_low = ^slot_word[1:0];

  for (genvar g = 0; g < N_AUDIO; g++) begin : g_lane
    assign hit[g] = slot_ok && (slot_num == 4'(AUDIO_SLOT[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q       <= '0;
      idx_q       <= '0;
      codec_ready <= 1'b0;
      smp_stb     <= '0;
      smp_data    <= '0;
      rd_valid    <= 1'b0;
      rd_index    <= '0;
      rd_data     <= '0;
      sr_need     <= '0;
    end else begin
      smp_stb  <= hit;
      rd_valid <= 1'b0;
      if (|hit) smp_data <= rounded[OUT_W-1:0];
      if (slot_end) begin
        case (slot_num)
          4'd0: begin
            tag_q       <= slot_word[15:3];
            codec_ready <= slot_word[15];
          end
          4'd1: begin
            if (slot_ok) begin
              idx_q   <= slot_word[18:12];
              sr_need <= ~{slot_word[3], slot_word[4], slot_word[5], slot_word[6],
                           slot_word[7], slot_word[8], slot_word[10], slot_word[11]};
            end else begin
              sr_need <= '0;
            end
          end
          4'd2: begin
            if (slot_ok && tag_q[14]) begin
              rd_valid <= 1'b1;
              rd_data  <= slot_word[19:4];
              rd_index <= idx_q;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aclink_capture_rx.sv
module aclink_capture_rx
  import aclink_rx_pkg::*;
#(
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  input  logic             sync_in,
  input  logic             sdata_in,
  output logic             codec_ready,
  output logic [5:0]       smp_stb,
  output logic [OUT_W-1:0] smp_data,
  output logic             rd_valid,
  output logic [6:0]       rd_index,
  output logic [15:0]      rd_data,
  output logic [7:0]       sr_need
);
  logic                 bit_stb;
  logic                 bit_dat;
  logic                 bit_sync;
  logic                 slot_end;
  logic [3:0]           slot_num;
  logic [SLOT_BITS-1:0] slot_word;

  aclink_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync_in(sync_in),
    .sdata_in(sdata_in), .bit_stb(bit_stb), .bit_dat(bit_dat), .bit_sync(bit_sync)
  );

  aclink_rx_framer framer_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_dat(bit_dat),
    .bit_sync(bit_sync), .slot_end(slot_end), .slot_num(slot_num),
    .slot_word(slot_word)
  );

  aclink_rx_decode #(.OUT_W(OUT_W)) decode_i (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .slot_num(slot_num),
    .slot_word(slot_word), .codec_ready(codec_ready), .smp_stb(smp_stb),
    .smp_data(smp_data), .rd_valid(rd_valid), .rd_index(rd_index),
    .rd_data(rd_data), .sr_need(sr_need)
  );
endmodule

// File: rtl/aclink_capture_rx_chk.sv
module aclink_capture_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       codec_ready,
  input logic [5:0] smp_stb,
  input logic       rd_valid,
  input logic [7:0] sr_need,
  input logic       slot_end,
  input logic [3:0] slot_num
);
  // R11
  smp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(smp_stb));

  // R11
  smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb != 6'd0) |=> (smp_stb == 6'd0));

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (smp_stb == 6'd0));

  // R3
  fwd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || smp_stb != 6'd0) |-> codec_ready);

  // R9
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && slot_num == 4'd1) |=> $stable(sr_need));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_end && slot_num == 4'd0) |=> $stable(codec_ready));
endmodule

bind aclink_capture_rx aclink_capture_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .codec_ready(codec_ready), .smp_stb(smp_stb),
  .rd_valid(rd_valid), .sr_need(sr_need), .slot_end(slot_end), .slot_num(slot_num)
);

// File: tb/aclink_capture_rx_tb_top.sv
module aclink_capture_rx_tb_top;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_clk = 1'b0;
  logic             sync_in = 1'b0;
  logic             sdata_in = 1'b0;
  logic             codec_ready;
  logic [5:0]       smp_stb;
  logic [OUT_W-1:0] smp_data;
  logic             rd_valid;
  logic [6:0]       rd_index;
  logic [15:0]      rd_data;
  logic [7:0]       sr_need;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string phase_req = "R12";

  int exp_kind[$];
  int exp_val[$];
  logic [19:0] slot_v [1:12];

  always #2 clk = ~clk;

  aclink_capture_rx #(.OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync_in(sync_in),
    .sdata_in(sdata_in), .codec_ready(codec_ready), .smp_stb(smp_stb),
    .smp_data(smp_data), .rd_valid(rd_valid), .rd_index(rd_index),
    .rd_data(rd_data), .sr_need(sr_need)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference rounding: integer division with floor, then clamp
  function automatic int ref_round(input logic [19:0] word);
    int v, step, r, q, lim;
    v = int'($signed(word[19:2]));
    if (OUT_W >= 18) return v;
    step = 1 << (18 - OUT_W);
    r = v + step / 2;
    q = r / step;
    if (r < 0 && (r % step) != 0) q = q - 1;
    lim = (1 << (OUT_W - 1)) - 1;
    if (q > lim) q = lim;
    return q;
  endfunction

  function automatic int lane_slot(input int lane);
    case (lane)
      0: return 3; 1: return 4; 2: return 6;
      3: return 7; 4: return 8; default: return 11;
    endcase
  endfunction

  // monitor: compare every event against the queue of expected ones
  always @(negedge clk) begin
    if (rst_n && (smp_stb != 6'd0 || rd_valid)) begin
      int kind, val;
      check("R11", $countones(smp_stb) + int'(rd_valid), 1);
      if (rd_valid) begin
        kind = 2;
        val = int'({rd_index, rd_data});
      end else begin
        kind = 0;
        for (int i = 0; i < 6; i++) if (smp_stb[i]) kind = lane_slot(i);
        val = int'($signed(smp_data));
      end
      if (exp_kind.size() == 0) begin
        check({phase_req, " unexpected slot"}, kind, -1);
      end else begin
        int ek, ev;
        ek = exp_kind.pop_front();
        ev = exp_val.pop_front();
        check({phase_req, " slot"}, kind, ek);
        check((kind == 2) ? "R8 read data" : {phase_req, " R6 sample"}, val, ev);
      end
    end
  end

  task automatic drive_bit(input logic b, input logic s);
    @(posedge clk); #1;
    bit_clk = 1'b1; sdata_in = b; sync_in = s;
    @(posedge clk); @(posedge clk); #1;
    bit_clk = 1'b0;
    @(posedge clk);
  endtask

  function automatic logic frame_bit(input logic [15:0] tag, input int p);
    int n, off;
    if (p < 16) return tag[15 - p];
    n = (p - 16) / 20 + 1;
    off = (p - 16) % 20;
    return slot_v[n][19 - off];
  endfunction

  task automatic send_frame(input logic [15:0] tag, input int cut);
    int srpos[8] = '{11, 10, 8, 7, 6, 5, 4, 3};
    int sr_exp;
    for (int n = 2; n <= 11; n++) begin
      bit audio, done_slot;
      audio = (n == 3 || n == 4 || n == 6 || n == 7 || n == 8 || n == 11);
      done_slot = (16 + 20 * n - 1) < cut;
      if (!done_slot || !tag[15] || !tag[15 - n]) continue;
      if (n == 2) begin
        if (tag[14]) begin
          exp_kind.push_back(2);
          exp_val.push_back(int'({slot_v[1][18:12], slot_v[2][19:4]}));
        end
      end else if (audio) begin
        exp_kind.push_back(n);
        exp_val.push_back(ref_round(slot_v[n]));
      end
    end
    sr_exp = 0;
    if (tag[15] && tag[14])
      for (int i = 0; i < 8; i++) if (!slot_v[1][srpos[i]]) sr_exp |= (1 << i);
    for (int p = 0; p < cut; p++) begin
      drive_bit(frame_bit(tag, p), p < 16);
      if (p == 24) check("R2 codec_ready", int'(codec_ready), int'(tag[15]));
      if (p == 44) check("R9 sr_need", int'(sr_need), sr_exp);
    end
  endtask

  task automatic idle_bits(input int k);
    for (int i = 0; i < k; i++) drive_bit(1'($urandom), 1'b0);
  endtask

  task automatic drain(input string req);
    repeat (16) @(posedge clk);
    check({req, " pending"}, exp_kind.size(), 0);
  endtask

  task automatic fill_slots();
    for (int n = 1; n <= 12; n++) slot_v[n] = 20'($urandom);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 codec_ready", int'(codec_ready), 0);
    check("R1 sr_need", int'(sr_need), 0);
    check("R1 smp_stb", int'(smp_stb), 0);
    check("R1 rd_valid", int'(rd_valid), 0);

    // R12: noise before any frame marker
    phase_req = "R12";
    idle_bits(40);
    drain("R12");

    // R4 R5: all tag bits set, including reserved slots 5, 9, 10, 12
    phase_req = "R4 R5";
    fill_slots();
    send_frame(16'hFFF8, 256);
    phase_req = "R12";
    idle_bits(30);
    drain("R12");

    // R3: not ready, every other tag set
    phase_req = "R3";
    fill_slots();
    send_frame(16'h7FF8, 256);
    drain("R3");

    // R4 R8: slot 1 valid but slot 2 not, audio slots 3 and 8 only
    phase_req = "R4 R8";
    fill_slots();
    send_frame(16'hD080, 256);
    drain("R4");

    // R7: saturation and rounding edges; low bits set to show they are ignored
    phase_req = "R7";
    fill_slots();
    slot_v[3] = {18'h1FFFF, 2'b11};
    slot_v[4] = {18'h20000, 2'b01};
    slot_v[6] = {18'h3FFFF, 2'b10};
    slot_v[7] = {18'h1FFFD, 2'b11};
    slot_v[8] = {18'h1FFFE, 2'b00};
    slot_v[11] = {18'h3FFFE, 2'b11};
    send_frame(16'hFFF8, 256);
    drain("R7");

    // R10: marker rises on the last bit of slot 3; next frame starts at once
    phase_req = "R10";
    fill_slots();
    send_frame(16'hFFF8, 75);
    fill_slots();
    send_frame(16'hFFF8, 256);
    drain("R10");

    // R6: random frames
    phase_req = "R6";
    for (int f = 0; f < 6; f++) begin
      fill_slots();
      send_frame({1'b1, 15'($urandom)} & 16'hFFF8, 256);
    end
    phase_req = "R12";
    idle_bits(20);
    drain("R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule